// File: doc/BRIEF.md
# Streaming 2x2 Image Decimator

This block halves an 8-bit grayscale image in both directions while the image streams through it in raster order. Each accepted input pixel is placed at the next position of a frame whose width and height are parameters. The even-numbered rows go into a one-line store. While an odd row arrives, the block pairs each new pixel with the two pixels stored directly above, building 2x2 tiles that do not overlap. It reduces every tile to a single output pixel.

A run-time mode input picks the reduction. It selects either the brightest of the four pixels, or their mean rounded toward zero. The mode is sampled with the pixel that completes a tile.

Both data edges use valid/ready handshakes. An input pixel is taken on a clock edge where `in_vld` and `in_rdy` are both high. An output pixel is delivered on an edge where `out_vld` and `out_rdy` are both high. The block has a single output register and no queue, so `in_rdy` falls whenever that register holds a pixel the consumer has not yet taken. While the consumer stalls, the held pixel and `out_vld` do not change. The producer may hold `in_vld` low for any number of cycles, and nothing advances during those cycles.

Top module: `dec2_stream_top`

## Requirements
- R1: A frame of IMG_W x IMG_H accepted pixels yields exactly (IMG_W/2)*(IMG_H/2) output pixels, in raster order of the tiles. Each tile is made of rows 2i and 2i+1 and columns 2j and 2j+1, counted from 0.
- R2: With `in_mode` = 1 at tile completion, the output is the largest of the four tile pixels.
- R3: With `in_mode` = 0 at tile completion, the output is floor((a+b+c+d)/4). The sum is formed without overflow, so four pixels of 255 give 255.
- R4: The output pixel for a tile becomes valid on the clock edge that follows the acceptance of the tile's last pixel (odd row, odd column). No output appears at any other time.
- R5: A cycle with `in_vld` low advances no position and produces no output.
- R6: When IMG_W or IMG_H is odd, the last column or row is consumed and dropped. For a 5x5 frame, exactly 4 outputs appear.
- R7: While `out_vld` is high and `out_rdy` is low, `in_rdy` is low and `out_vld` and `out_pix` hold their values.
- R8: Synchronous reset clears the position counters, the output-valid flag and the held left pixel. After reset, `out_vld` is 0 and `in_rdy` is 1, and the next accepted pixel is row 0, column 0.
- R9: After the last pixel of a frame, the position wraps to row 0, column 0, so frames may follow back to back.
- R10: The mode is taken from `in_mode` at the tile's last pixel only. Its value on the other three pixels has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input pixel valid |
| in_rdy | output | 1 | Block can take an input pixel |
| in_pix | input | PIX_W | Input pixel |
| in_mode | input | 1 | Reduction select: 1 = maximum, 0 = mean |
| out_vld | output | 1 | Output pixel valid |
| out_rdy | input | 1 | Consumer takes the output pixel |
| out_pix | output | PIX_W | Output pixel |

## Verification
The first frame is a smooth gradient. It separates maximum from mean and shows whether the tiles are aligned to the right rows and columns. An all-255 frame exposes a sum that wraps in the mean path. A frame of small values whose sums are not multiples of four shows that the mean truncates rather than rounds. A pseudo-random frame changes the mode on every pixel while gaps and random consumer stalls are inserted. This frame tells apart sampling the mode at tile completion from sampling it on any other pixel, and it confirms that stalled output is held. Back-to-back frames, a reset in the middle of a frame, and a 5x5 instance check that the counters wrap, restart, and drop the trailing row and column.

// File: rtl/dec2_pkg.sv
package dec2_pkg;

  typedef enum logic {
    RED_MEAN = 1'b0,
    RED_MAX  = 1'b1
  } red_mode_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dec2_raster_pos.sv
module dec2_raster_pos #(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480,
  localparam int unsigned COL_W = dec2_pkg::idx_bits(IMG_W),
  localparam int unsigned ROW_W = dec2_pkg::idx_bits(IMG_H)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

  logic col_wrap;
  logic row_wrap;

  assign col_wrap = (col == COL_LAST);
  assign row_wrap = (row == ROW_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (step) begin
      if (col_wrap) begin
        col <= '0;
        row <= row_wrap ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dec2_row_store.sv
module dec2_row_store #(
  parameter int unsigned DEPTH = 640,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned ADDR_W = dec2_pkg::idx_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [PIX_W-1:0]  rd_data_a,
  output logic [PIX_W-1:0]  rd_data_b
);

  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];

endmodule

// File: rtl/dec2_quad_reduce.sv
module dec2_quad_reduce #(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned SUM_W = PIX_W + 2
) (
  input  logic [PIX_W-1:0]    up_l,
  input  logic [PIX_W-1:0]    up_r,
  input  logic [PIX_W-1:0]    dn_l,
  input  logic [PIX_W-1:0]    dn_r,
  input  dec2_pkg::red_mode_e mode,
  output logic [PIX_W-1:0]    result
);

  logic [PIX_W-1:0] max_up;
  logic [PIX_W-1:0] max_dn;
  logic [PIX_W-1:0] max_all;
  logic [SUM_W-1:0] sum4;
  logic [PIX_W-1:0] mean4;

  always_comb begin
    max_up  = (up_l > up_r) ? up_l : up_r;
    max_dn  = (dn_l > dn_r) ? dn_l : dn_r;
    max_all = (max_up > max_dn) ? max_up : max_dn;
  end

  always_comb begin
    sum4  = SUM_W'(up_l) + SUM_W'(up_r) + SUM_W'(dn_l) + SUM_W'(dn_r);
    mean4 = sum4[SUM_W-1:2];
  end

  assign result = (mode == dec2_pkg::RED_MAX) ? max_all : mean4;

endmodule

// File: rtl/dec2_stream_top.sv
module dec2_stream_top #(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480,
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_mode,
  output logic             out_vld,
  input  logic             out_rdy,
  output logic [PIX_W-1:0] out_pix
);

  localparam int unsigned COL_W = dec2_pkg::idx_bits(IMG_W);
  localparam int unsigned ROW_W = dec2_pkg::idx_bits(IMG_H);

  logic             take;
  logic             tile_done;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col_left;
  logic [PIX_W-1:0] up_l;
  logic [PIX_W-1:0] up_r;
  logic [PIX_W-1:0] left_q;
  logic [PIX_W-1:0] reduced;
  logic             out_vld_q;
  logic [PIX_W-1:0] out_pix_q;

  assign in_rdy    = !out_vld_q || out_rdy;
  assign take      = in_vld && in_rdy;
  assign tile_done = take && row[0] && col[0];
  assign col_left  = {col[COL_W-1:1], 1'b0};

  dec2_raster_pos #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H)
  ) pos_i (
    .clk  (clk),
    .rst  (rst),
    .step (take),
    .col  (col),
    .row  (row)
  );

  dec2_row_store #(
    .DEPTH (IMG_W),
    .PIX_W (PIX_W)
  ) line_i (
    .clk       (clk),
    .wr_en     (take && !row[0]),
    .wr_addr   (col),
    .wr_data   (in_pix),
    .rd_addr_a (col_left),
    .rd_addr_b (col),
    .rd_data_a (up_l),
    .rd_data_b (up_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (take && row[0] && !col[0]) begin
      left_q <= in_pix;
    end
  end

  dec2_quad_reduce #(
    .PIX_W (PIX_W)
  ) reduce_i (
    .up_l   (up_l),
    .up_r   (up_r),
    .dn_l   (left_q),
    .dn_r   (in_pix),
    .mode   (dec2_pkg::red_mode_e'(in_mode)),
    .result (reduced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_q <= 1'b0;
    end else if (tile_done) begin
      out_vld_q <= 1'b1;
    end else if (out_rdy) begin
      out_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tile_done) begin
      out_pix_q <= reduced;
    end
  end

  assign out_vld = out_vld_q;
  assign out_pix = out_pix_q;

endmodule

// File: rtl/dec2_stream_chk.sv
module dec2_stream_chk #(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480,
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             in_rdy,
  input logic             out_vld,
  input logic             out_rdy,
  input logic [PIX_W-1:0] out_pix
);

  int unsigned mc;
  int unsigned mr;
  logic        tile_seen;
  logic        acc;

  assign acc = in_vld && in_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc        <= 0;
      mr        <= 0;
      tile_seen <= 1'b0;
    end else begin
      tile_seen <= acc && mc[0] && mr[0];
      if (acc) begin
        if (mc == IMG_W - 1) begin
          mc <= 0;
          mr <= (mr == IMG_H - 1) ? 0 : mr + 1;
        end else begin
          mc <= mc + 1;
        end
      end
    end
  end

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_vld);

  assert_tile_output_R4: assert property (@(posedge clk) disable iff (rst)
    tile_seen |-> out_vld);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    (!tile_seen && !$past(out_vld && !out_rdy)) |-> !out_vld);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_pix)));

  assert_stall_blocks_input_R7: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |-> !in_rdy);

endmodule

bind dec2_stream_top dec2_stream_chk #(
  .IMG_W (IMG_W),
  .IMG_H (IMG_H),
  .PIX_W (PIX_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .in_rdy  (in_rdy),
  .out_vld (out_vld),
  .out_rdy (out_rdy),
  .out_pix (out_pix)
);

// File: tb/dec2_stream_top_tb_top.sv
`timescale 1ns/100ps
module dec2_stream_top_tb_top;

  localparam int W0 = 8;
  localparam int H0 = 6;
  localparam int W1 = 5;
  localparam int H1 = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic       in_vld2 = 1'b0;
  logic [7:0] in_pix = '0;
  logic       in_mode = 1'b0;
  logic       out_rdy = 1'b1;
  logic       in_rdy, in_rdy2, out_vld, out_vld2;
  logic [7:0] out_pix, out_pix2;

  int checks = 0;
  int errors = 0;
  int out_cnt0 = 0;
  int out_cnt2 = 0;
  bit bp_on = 1'b0;
  int unsigned lfsr = 32'h1ace_b00c;
  int unsigned bp_lfsr = 32'h0bad_cafe;

  logic [7:0] exp_q0 [$];
  string      tag_q0 [$];
  logic [7:0] exp_q1 [$];
  string      tag_q1 [$];
  int         img [0:7][0:7];

  always #2 clk = ~clk;

  dec2_stream_top #(.IMG_W(W0), .IMG_H(H0), .PIX_W(8)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy), .in_pix(in_pix),
    .in_mode(in_mode), .out_vld(out_vld), .out_rdy(out_rdy), .out_pix(out_pix)
  );

  dec2_stream_top #(.IMG_W(W1), .IMG_H(H1), .PIX_W(8)) dut_odd_i (
    .clk(clk), .rst(rst), .in_vld(in_vld2), .in_rdy(in_rdy2), .in_pix(in_pix),
    .in_mode(in_mode), .out_vld(out_vld2), .out_rdy(1'b1), .out_pix(out_pix2)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int unsigned step_lfsr(input int unsigned s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  always @(negedge clk) begin
    bp_lfsr = step_lfsr(bp_lfsr);
    out_rdy = bp_on ? bp_lfsr[3] : 1'b1;
  end

  // scoreboard monitors
  initial begin
    bit         prev_stall = 1'b0;
    logic [7:0] prev_pix = '0;
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (prev_stall) check(out_vld && out_pix == prev_pix, "R7 hold", int'(out_pix), int'(prev_pix));
        if (out_vld && !out_rdy) check(!in_rdy, "R7 ready", int'(in_rdy), 0);
        if (out_vld && out_rdy) begin
          out_cnt0++;
          if (exp_q0.size() == 0) check(1'b0, "R4 extra output", int'(out_pix), -1);
          else begin
            logic [7:0] e;
            string t;
            e = exp_q0.pop_front();
            t = tag_q0.pop_front();
            check(out_pix == e, t, int'(out_pix), int'(e));
          end
        end
        prev_stall = out_vld && !out_rdy;
        prev_pix = out_pix;
      end else prev_stall = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_vld2) begin
        out_cnt2++;
        if (exp_q1.size() == 0) check(1'b0, "R6 extra output", int'(out_pix2), -1);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q1.pop_front();
          t = tag_q1.pop_front();
          check(out_pix2 == e, t, int'(out_pix2), int'(e));
        end
      end
    end
  end

  function automatic int pix_fn(input int pat, input int r, input int c, input int w);
    case (pat)
      0: return (r * 29 + c * 13 + 7) & 255;
      1: return 255;
      2: return (r * 3 + c + ((r * w + c) % 3)) % 4;
      default: return -1;
    endcase
  endfunction

  task automatic idle(input int n);
    @(negedge clk);
    in_vld = 1'b0;
    in_vld2 = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic push_pix(input int sel, input logic [7:0] p, input logic m);
    @(negedge clk);
    in_pix = p;
    in_mode = m;
    if (sel == 0) in_vld = 1'b1; else in_vld2 = 1'b1;
    forever begin
      #1;
      if ((sel == 0) ? in_rdy : in_rdy2) break;
      @(negedge clk);
    end
  endtask

  // mmode: 0 mean, 1 max, 2 changes every pixel
  task automatic send_frame(input int sel, input int w, input int rows, input int pat,
                            input int mmode, input bit gaps, input bit lat_chk, input string tag);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < w; c++) begin
        int p;
        logic m;
        p = pix_fn(pat, r, c, w);
        if (p < 0) begin
          lfsr = step_lfsr(lfsr);
          p = int'(lfsr[15:8]);
        end
        img[r][c] = p;
        if (mmode == 2) begin
          lfsr = step_lfsr(lfsr);
          m = lfsr[5];
        end else m = (mmode == 1);
        if (r[0] && c[0]) begin
          int a, b, d, mx, e;
          a = img[r-1][c-1]; b = img[r-1][c]; d = img[r][c-1];
          mx = a; if (b > mx) mx = b; if (d > mx) mx = d; if (p > mx) mx = p;
          e = m ? mx : ((a + b + d + p) >> 2);
          if (sel == 0) begin exp_q0.push_back(8'(e)); tag_q0.push_back(tag); end
          else begin exp_q1.push_back(8'(e)); tag_q1.push_back(tag); end
        end
        push_pix(sel, 8'(p), m);
        if (lat_chk && r[0] && c[0]) begin
          @(negedge clk);
          in_vld = 1'b0;
          #1;
          check(out_vld == 1'b1, "R4 latency", int'(out_vld), 1);
        end
        if (gaps && ((r * w + c) % 5 == 2)) idle(2);
      end
    end
    idle(1);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (exp_q0.size() == 0 && exp_q1.size() == 0 && !out_vld && !out_vld2) break;
    end
    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R1 drain", exp_q0.size() + exp_q1.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    #1;
    check(out_vld == 1'b0, "R8 reset out_vld", int'(out_vld), 0);
    rst = 1'b0;
    #1;
    check(in_rdy == 1'b1, "R8 reset in_rdy", int'(in_rdy), 1);

    send_frame(0, W0, H0, 0, 0, 1'b0, 1'b1, "R3 mean gradient");
    drain();
    check(out_cnt0 == (W0 / 2) * (H0 / 2), "R1 output count", out_cnt0, (W0 / 2) * (H0 / 2));
    send_frame(0, W0, H0, 0, 1, 1'b0, 1'b0, "R2 max gradient R9");
    send_frame(0, W0, H0, 1, 0, 1'b0, 1'b0, "R3 mean all-255");
    send_frame(0, W0, H0, 1, 1, 1'b0, 1'b0, "R2 max all-255");
    send_frame(0, W0, H0, 2, 0, 1'b0, 1'b0, "R3 mean truncation");
    drain();

    bp_on = 1'b1;
    send_frame(0, W0, H0, 3, 2, 1'b1, 1'b0, "R10 mode per tile with stalls R5");
    send_frame(0, W0, H0, 3, 1, 1'b1, 1'b0, "R7 max random with stalls");
    drain();
    bp_on = 1'b0;

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1;
      check(out_vld == 1'b0, "R5 idle no output", int'(out_vld), 0);
    end

    base = out_cnt0;
    send_frame(0, W0, 3, 0, 1, 1'b0, 1'b0, "R8 partial before reset");
    drain();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(out_vld == 1'b0, "R8 mid-run reset", int'(out_vld), 0);
    rst = 1'b0;
    send_frame(0, W0, H0, 0, 0, 1'b0, 1'b0, "R8 frame after reset");
    drain();
    check(out_cnt0 - base == (W0 / 2) * (H0 / 2) + (W0 / 2),
          "R1 count around reset", out_cnt0 - base, (W0 / 2) * (H0 / 2) + (W0 / 2));

    send_frame(1, W1, H1, 0, 1, 1'b0, 1'b0, "R6 odd frame max");
    send_frame(1, W1, H1, 3, 0, 1'b0, 1'b0, "R6 odd frame mean");
    drain();
    check(out_cnt2 == 8, "R6 odd output count", out_cnt2, 8);

    finish_run();
  end

endmodule